// File: doc/BRIEF.md
# Command Word Parser for a Register and Memory Access Port

This block sits behind the byte layer of a two-wire serial slave. It takes complete 16-bit words and the subaddress each was written to. Words sent to the data subaddress form commands. The top nibble of a command's first word is the opcode. The parser decodes it, gathers any parameter words that follow, and drives one of three access ports:

- a register port with an 8-bit address and 20-bit values;
- a two-bank memory port with an 11-bit address and 20-bit values;
- a 64-entry status window port with 16-bit values.

Values of 20 bits do not fit in one 16-bit word, so they travel as two words. The first word holds the low 16 bits. The second word holds bits 19:16 in its low nibble.

Words produced by read commands go into a small response queue. The host drains that queue through `rd_req_i`. If the host reads while the queue is empty, it gets the current frame counter value instead.

A word written to the control subaddress does two things. It can request a software reset, which returns the parser to idle, empties the queue and clears the error flag. It also loads a 4-bit task selector.

Top module: `cmd_word_parser`

## Requirements
- R1: In idle, a data word whose top nibble is 0x0 or 0x1 raises `run_o` for that cycle, with `run_addr_o` equal to the whole word.
- R2: Opcode 0x9 writes a register. The first word carries the register number in bits 11:4 and value bit field 3:0 in bits 3:0. The second word carries value bits 19:4. One `reg_we_o` strobe appears in the cycle of the second word.
- R3: Opcode 0xD reads the register numbered by bits 11:4. It queues two words: value bits 15:0, then a word whose bits 3:0 hold value bits 19:16 and whose upper bits are zero.
- R4: Opcode 0xA writes memory bank 0 and opcode 0xB writes bank 1. The next word is a count and the word after it is a start address (bits 10:0). Then come two words per value, low word first. Each pair produces one `mem_we_o` strobe, at consecutive addresses.
- R5: Opcode 0xE reads bank 0 and opcode 0xF reads bank 1. They take the same count and address words as R4. For each address they queue the low word and then the high-nibble word. The queue never overflows.
- R6: Opcode 0x3 reads the status window. The offset is bits 11:6 and the word count is bits 5:0. It queues that many words from consecutive status addresses, which wrap modulo 64.
- R7: A host read while the queue is empty returns `frame_count_i` and changes nothing.
- R8: Opcodes 0x2, 0x4 to 0x8 and 0xC are dropped. They set the sticky `err_o` one cycle later, and the parser is ready for the next word.
- R9: A block transfer that goes on past address 2047 continues at address 0 and sets `err_o`.
- R10: A word at subaddress 0x6A loads `task_o` from bits 3:0 one cycle later. If bit 8 is set, `sw_reset_o` pulses for one cycle; the parser then returns to idle, the queue empties and `err_o` clears.
- R11: A memory command with a count of zero ends after its address word without any access.
- R12: Words at any subaddress other than 0x68 and 0x6A cause no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | A whole written word is present |
| wr_sub_i | input | 8 | Subaddress of that word |
| wr_word_i | input | 16 | Written word |
| rd_req_i | input | 1 | Host reads one response word |
| rd_word_o | output | 16 | Queue head, or the frame counter when the queue is empty |
| frame_count_i | input | 16 | Frame counter value |
| run_o | output | 1 | Run request strobe |
| run_addr_o | output | 16 | Run start address |
| reg_we_o | output | 1 | Register write strobe |
| reg_re_o | output | 1 | Register read strobe |
| reg_addr_o | output | 8 | Register number |
| reg_wdata_o | output | 20 | Register write value |
| reg_rdata_i | input | 20 | Register read value, same cycle |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe |
| mem_bank_o | output | 1 | Memory bank select |
| mem_addr_o | output | 11 | Memory address |
| mem_wdata_o | output | 20 | Memory write value |
| mem_rdata_i | input | 20 | Memory read value, same cycle |
| stat_re_o | output | 1 | Status window read strobe |
| stat_addr_o | output | 6 | Status window address |
| stat_rdata_i | input | 16 | Status word, same cycle |
| sw_reset_o | output | 1 | Software reset pulse |
| task_o | output | 4 | Task selector |
| err_o | output | 1 | Sticky command error flag |

## Verification
Run and write strobes are combinational on the word that completes a command. They are sampled in the middle of that word's cycle. `err_o` and `task_o` are registered, so they are checked one cycle after the word. Software reset effects are checked two cycles after the word: one cycle to form the pulse and one for the clear. The first response word can enter the queue at the earliest one cycle after the final parameter word. For that reason the bench leaves several idle cycles before each host read and samples `rd_word_o` on the falling edge of the read cycle.

// File: rtl/cwp_pkg.sv
package cwp_pkg;
  localparam int WORD_W = 16;
  localparam int VAL_W  = 20;
  localparam int CNT_W  = 16;

  localparam logic [7:0] SUB_DATA = 8'h68;
  localparam logic [7:0] SUB_CTRL = 8'h6A;

  typedef enum logic [3:0] {
    S_IDLE, S_REG_HI, S_REG_RD, S_RD_HI, S_MEM_CNT,
    S_MEM_ADR, S_MEM_WLO, S_MEM_WHI, S_MEM_RD, S_STAT_RD
  } state_e;
endpackage

// File: rtl/cwp_fifo.sv
module cwp_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o,
  output logic         room2_o
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign room2_o = (cnt_q <= (AW+1)'(DEPTH - 2));
  assign dout_o  = mem_q[rp_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else if (clr_i) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= nxt(wp_q);
      if (pop_i)  rp_q <= nxt(rp_q);
      cnt_q <= cnt_q + (AW+1)'(push_i) - (AW+1)'(pop_i);
    end
  end

  always_ff @(posedge clk_i) if (push_i) mem_q[wp_q] <= din_i;

  assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (!full_o || pop_i));
  assert_no_underflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/cwp_ctrl.sv
module cwp_ctrl (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       rst_bit_i,
  input  logic [3:0] task_i,
  output logic       sw_reset_o,
  output logic [3:0] task_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_reset_o <= 1'b0;
      task_o     <= '0;
    end else begin
      sw_reset_o <= wr_i && rst_bit_i;
      if (wr_i) task_o <= task_i;
    end
  end
endmodule

// File: rtl/cwp_parser.sv
module cwp_parser import cwp_pkg::*; #(
  parameter int REG_AW  = 8,
  parameter int MEM_AW  = 11,
  parameter int STAT_AW = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                soft_rst_i,
  input  logic                word_v_i,
  input  logic [WORD_W-1:0]   word_i,
  input  logic                room2_i,
  input  logic                not_full_i,
  output logic                push_o,
  output logic [WORD_W-1:0]   push_word_o,
  output logic                run_o,
  output logic                reg_we_o,
  output logic                reg_re_o,
  output logic [REG_AW-1:0]   reg_addr_o,
  output logic [VAL_W-1:0]    reg_wdata_o,
  input  logic [VAL_W-1:0]    reg_rdata_i,
  output logic                mem_we_o,
  output logic                mem_re_o,
  output logic                mem_bank_o,
  output logic [MEM_AW-1:0]   mem_addr_o,
  output logic [VAL_W-1:0]    mem_wdata_o,
  input  logic [VAL_W-1:0]    mem_rdata_i,
  output logic                stat_re_o,
  output logic [STAT_AW-1:0]  stat_addr_o,
  input  logic [WORD_W-1:0]   stat_rdata_i,
  output logic                err_o
);
  localparam int HI_W = VAL_W - WORD_W;
  localparam logic [MEM_AW-1:0] MEM_LAST = '1;

  state_e state_q, state_d;
  logic [REG_AW-1:0]  reg_q, reg_d;
  logic [WORD_W-1:0]  lo_q, lo_d;
  logic [HI_W-1:0]    hi_q, hi_d;
  logic [MEM_AW-1:0]  addr_q, addr_d;
  logic [STAT_AW-1:0] off_q, off_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic bank_q, bank_d, wr_q, wr_d, last_q, last_d, err_q, err_set;
  logic [3:0] op;

  assign op          = word_i[15:12];
  assign reg_addr_o  = reg_q;
  assign reg_wdata_o = {word_i, lo_q[HI_W-1:0]};
  assign mem_bank_o  = bank_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = {word_i[HI_W-1:0], lo_q};
  assign stat_addr_o = off_q;
  assign err_o       = err_q;

  always_comb begin
    state_d = state_q; reg_d = reg_q; lo_d = lo_q; hi_d = hi_q;
    addr_d = addr_q; off_d = off_q; cnt_d = cnt_q;
    bank_d = bank_q; wr_d = wr_q; last_d = last_q; err_set = 1'b0;
    push_o = 1'b0; push_word_o = '0; run_o = 1'b0;
    reg_we_o = 1'b0; reg_re_o = 1'b0; mem_we_o = 1'b0; mem_re_o = 1'b0;
    stat_re_o = 1'b0;
    case (state_q)
      S_IDLE: if (word_v_i) begin
        case (op)
          4'h0, 4'h1: run_o = 1'b1;
          4'h3: begin
            off_d   = word_i[6 +: STAT_AW];
            cnt_d   = CNT_W'(word_i[5:0]);
            state_d = (word_i[5:0] == '0) ? S_IDLE : S_STAT_RD;
          end
          4'h9: begin
            reg_d = word_i[4 +: REG_AW]; lo_d = word_i; state_d = S_REG_HI;
          end
          4'hD: begin
            reg_d = word_i[4 +: REG_AW]; state_d = S_REG_RD;
          end
          4'hA, 4'hB, 4'hE, 4'hF: begin
            bank_d = word_i[12]; wr_d = !word_i[14]; state_d = S_MEM_CNT;
          end
          default: err_set = 1'b1;
        endcase
      end
      S_REG_HI: if (word_v_i) begin
        reg_we_o = 1'b1; state_d = S_IDLE;
      end
      S_REG_RD: if (room2_i) begin
        reg_re_o = 1'b1; push_o = 1'b1; push_word_o = reg_rdata_i[WORD_W-1:0];
        hi_d = reg_rdata_i[VAL_W-1:WORD_W]; last_d = 1'b1; state_d = S_RD_HI;
      end
      S_RD_HI: begin
        push_o = 1'b1; push_word_o = WORD_W'(hi_q);
        state_d = last_q ? S_IDLE : S_MEM_RD;
      end
      S_MEM_CNT: if (word_v_i) begin
        cnt_d = word_i; state_d = S_MEM_ADR;
      end
      S_MEM_ADR: if (word_v_i) begin
        addr_d  = word_i[MEM_AW-1:0];
        state_d = (cnt_q == '0) ? S_IDLE : (wr_q ? S_MEM_WLO : S_MEM_RD);
      end
      S_MEM_WLO: if (word_v_i) begin
        lo_d = word_i; state_d = S_MEM_WHI;
      end
      S_MEM_WHI: if (word_v_i) begin
        mem_we_o = 1'b1;
        addr_d = addr_q + 1'b1; cnt_d = cnt_q - 1'b1;
        if (addr_q == MEM_LAST && cnt_q != CNT_W'(1)) err_set = 1'b1;
        state_d = (cnt_q == CNT_W'(1)) ? S_IDLE : S_MEM_WLO;
      end
      S_MEM_RD: if (room2_i) begin
        mem_re_o = 1'b1; push_o = 1'b1; push_word_o = mem_rdata_i[WORD_W-1:0];
        hi_d = mem_rdata_i[VAL_W-1:WORD_W];
        addr_d = addr_q + 1'b1; cnt_d = cnt_q - 1'b1;
        if (addr_q == MEM_LAST && cnt_q != CNT_W'(1)) err_set = 1'b1;
        last_d = (cnt_q == CNT_W'(1)); state_d = S_RD_HI;
      end
      S_STAT_RD: if (not_full_i) begin
        stat_re_o = 1'b1; push_o = 1'b1; push_word_o = stat_rdata_i;
        off_d = off_q + 1'b1; cnt_d = cnt_q - 1'b1;
        state_d = (cnt_q == CNT_W'(1)) ? S_IDLE : S_STAT_RD;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE; reg_q <= '0; lo_q <= '0; hi_q <= '0; addr_q <= '0;
      off_q <= '0; cnt_q <= '0; bank_q <= 1'b0; wr_q <= 1'b0; last_q <= 1'b0;
      err_q <= 1'b0;
    end else if (soft_rst_i) begin
      state_q <= S_IDLE; err_q <= 1'b0;
    end else begin
      state_q <= state_d; reg_q <= reg_d; lo_q <= lo_d; hi_q <= hi_d;
      addr_q <= addr_d; off_q <= off_d; cnt_q <= cnt_d; bank_q <= bank_d;
      wr_q <= wr_d; last_q <= last_d; err_q <= err_q | err_set;
    end
  end

  assert_one_access_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({run_o, reg_we_o, reg_re_o, mem_we_o, mem_re_o, stat_re_o}));
  assert_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !soft_rst_i) |=> err_o);
  assert_wrap_err_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mem_we_o || mem_re_o) && mem_addr_o == MEM_LAST && cnt_q != CNT_W'(1)
     && !soft_rst_i) |=> (err_o && mem_addr_o == '0));
endmodule

// File: rtl/cmd_word_parser.sv
module cmd_word_parser import cwp_pkg::*; #(
  parameter int REG_AW     = 8,
  parameter int MEM_AW     = 11,
  parameter int STAT_AW    = 6,
  parameter int FIFO_DEPTH = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_valid_i,
  input  logic [7:0]         wr_sub_i,
  input  logic [15:0]        wr_word_i,
  input  logic               rd_req_i,
  output logic [15:0]        rd_word_o,
  input  logic [15:0]        frame_count_i,
  output logic               run_o,
  output logic [15:0]        run_addr_o,
  output logic               reg_we_o,
  output logic               reg_re_o,
  output logic [REG_AW-1:0]  reg_addr_o,
  output logic [19:0]        reg_wdata_o,
  input  logic [19:0]        reg_rdata_i,
  output logic               mem_we_o,
  output logic               mem_re_o,
  output logic               mem_bank_o,
  output logic [MEM_AW-1:0]  mem_addr_o,
  output logic [19:0]        mem_wdata_o,
  input  logic [19:0]        mem_rdata_i,
  output logic               stat_re_o,
  output logic [STAT_AW-1:0] stat_addr_o,
  input  logic [15:0]        stat_rdata_i,
  output logic               sw_reset_o,
  output logic [3:0]         task_o,
  output logic               err_o
);
  logic data_v, ctrl_v, push, pop, empty, full, room2;
  logic [WORD_W-1:0] push_word, head;

  assign data_v     = wr_valid_i && (wr_sub_i == SUB_DATA);
  assign ctrl_v     = wr_valid_i && (wr_sub_i == SUB_CTRL);
  assign run_addr_o = wr_word_i;
  assign pop        = rd_req_i && !empty;
  assign rd_word_o  = empty ? frame_count_i : head;

  cwp_ctrl u_ctrl (
    .clk_i, .rst_ni, .wr_i(ctrl_v), .rst_bit_i(wr_word_i[8]),
    .task_i(wr_word_i[3:0]), .sw_reset_o, .task_o
  );

  cwp_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni, .clr_i(sw_reset_o), .push_i(push), .din_i(push_word),
    .pop_i(pop), .dout_o(head), .empty_o(empty), .full_o(full), .room2_o(room2)
  );

  cwp_parser #(.REG_AW(REG_AW), .MEM_AW(MEM_AW), .STAT_AW(STAT_AW)) u_parser (
    .clk_i, .rst_ni, .soft_rst_i(sw_reset_o), .word_v_i(data_v), .word_i(wr_word_i),
    .room2_i(room2), .not_full_i(!full), .push_o(push), .push_word_o(push_word),
    .run_o, .reg_we_o, .reg_re_o, .reg_addr_o, .reg_wdata_o, .reg_rdata_i,
    .mem_we_o, .mem_re_o, .mem_bank_o, .mem_addr_o, .mem_wdata_o, .mem_rdata_i,
    .stat_re_o, .stat_addr_o, .stat_rdata_i, .err_o
  );

  assert_flush_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_reset_o |=> (empty && !err_o));
endmodule

// File: tb/cmd_word_parser_bench.sv
`timescale 1ns/1ps
module cmd_word_parser_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, rd_req = 1'b0;
  logic [7:0] wr_sub = '0;
  logic [15:0] wr_word = '0, frame_count = 16'h0abc;
  logic [15:0] rd_word, run_addr;
  logic run, reg_we, reg_re, mem_we, mem_re, mem_bank, stat_re, sw_reset, err;
  logic [7:0] reg_addr;
  logic [10:0] mem_addr;
  logic [5:0] stat_addr;
  logic [19:0] reg_wdata, reg_rdata, mem_wdata, mem_rdata;
  logic [15:0] stat_rdata;
  logic [3:0] task_sel;
  int n_cmp = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  function automatic logic [19:0] mem_model(input logic b, input logic [10:0] a);
    return 20'(({9'd0, a} * 20'd40503)) ^ (b ? 20'h9c5a3 : 20'h3a71e);
  endfunction
  function automatic logic [19:0] reg_model(input logic [7:0] a);
    return {a, a, a[3:0]} ^ 20'h5b6c7;
  endfunction
  function automatic logic [15:0] stat_model(input logic [5:0] a);
    return 16'({10'd0, a} * 16'd1337) + 16'h1234;
  endfunction

  assign mem_rdata  = mem_model(mem_bank, mem_addr);
  assign reg_rdata  = reg_model(reg_addr);
  assign stat_rdata = stat_model(stat_addr);

  cmd_word_parser u_cmd_word_parser (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_sub_i(wr_sub),
    .wr_word_i(wr_word), .rd_req_i(rd_req), .rd_word_o(rd_word),
    .frame_count_i(frame_count), .run_o(run), .run_addr_o(run_addr),
    .reg_we_o(reg_we), .reg_re_o(reg_re), .reg_addr_o(reg_addr),
    .reg_wdata_o(reg_wdata), .reg_rdata_i(reg_rdata), .mem_we_o(mem_we),
    .mem_re_o(mem_re), .mem_bank_o(mem_bank), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .stat_re_o(stat_re),
    .stat_addr_o(stat_addr), .stat_rdata_i(stat_rdata), .sw_reset_o(sw_reset),
    .task_o(task_sel), .err_o(err)
  );

  // access log: kind 0 run, 1 register, 2 bank0, 3 bank1
  int lg_n = 0;
  int lg_kind [64];
  logic [15:0] lg_addr [64];
  logic [19:0] lg_data [64];
  always @(negedge clk) if (rst_n && lg_n < 64) begin
    if (run)    begin lg_kind[lg_n] = 0; lg_addr[lg_n] = run_addr; lg_data[lg_n] = '0; lg_n++; end
    if (reg_we) begin lg_kind[lg_n] = 1; lg_addr[lg_n] = 16'(reg_addr); lg_data[lg_n] = reg_wdata; lg_n++; end
    if (mem_we) begin lg_kind[lg_n] = 2 + int'(mem_bank); lg_addr[lg_n] = 16'(mem_addr);
                      lg_data[lg_n] = mem_wdata; lg_n++; end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] sub, input logic [15:0] w);
    @(posedge clk); #1;
    wr_valid = 1'b1; wr_sub = sub; wr_word = w;
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic rd(output logic [15:0] w);
    repeat (4) @(posedge clk);
    #1 rd_req = 1'b1;
    @(negedge clk) w = rd_word;
    @(posedge clk); #1 rd_req = 1'b0;
  endtask

  task automatic mem_write(input logic b, input int cnt, input logic [10:0] a, input string tag);
    int base = lg_n;
    logic [19:0] vals [8];
    send(8'h68, {(b ? 4'hB : 4'hA), 12'h000});
    send(8'h68, 16'(cnt));
    send(8'h68, {5'd0, a});
    for (int i = 0; i < cnt; i++) begin
      vals[i] = 20'($urandom);
      send(8'h68, vals[i][15:0]);
      send(8'h68, {12'h000, vals[i][19:16]});
    end
    chk(lg_n - base == cnt, tag, 32'(lg_n - base), 32'(cnt));
    for (int i = 0; i < cnt && base + i < 64; i++) begin
      chk(lg_kind[base+i] == 2 + int'(b), tag, 32'(lg_kind[base+i]), 32'(2 + int'(b)));
      chk(lg_addr[base+i] == 16'(11'(a + 11'(i))), tag, 32'(lg_addr[base+i]), 32'(11'(a + 11'(i))));
      chk(lg_data[base+i] == vals[i], tag, 32'(lg_data[base+i]), 32'(vals[i]));
    end
  endtask

  task automatic mem_read(input logic b, input int cnt, input logic [10:0] a, input string tag);
    logic [15:0] lo, hi;
    logic [19:0] e;
    send(8'h68, {(b ? 4'hF : 4'hE), 12'h000});
    send(8'h68, 16'(cnt));
    send(8'h68, {5'd0, a});
    for (int i = 0; i < cnt; i++) begin
      e = mem_model(b, 11'(a + 11'(i)));
      rd(lo); rd(hi);
      chk({hi, lo} == {12'h000, e}, tag, {hi, lo}, {12'h000, e});
    end
  endtask

  task automatic reg_write(input logic [7:0] r, input logic [19:0] v);
    int base = lg_n;
    send(8'h68, {4'h9, r, v[3:0]});
    send(8'h68, v[19:4]);
    chk(lg_n - base == 1, "R2 count", 32'(lg_n - base), 1);
    chk(lg_kind[base] == 1 && lg_addr[base] == 16'(r), "R2 addr", 32'(lg_addr[base]), 32'(r));
    chk(lg_data[base] == v, "R2 data", 32'(lg_data[base]), 32'(v));
  endtask

  task automatic reg_read(input logic [7:0] r);
    logic [15:0] lo, hi;
    logic [19:0] e = reg_model(r);
    send(8'h68, {4'hD, r, 4'h0});
    rd(lo); rd(hi);
    chk({hi, lo} == {12'h000, e}, "R3 reg read", {hi, lo}, {12'h000, e});
  endtask

  task automatic stat_read(input logic [5:0] off, input logic [5:0] cnt);
    logic [15:0] w;
    send(8'h68, {4'h3, off, cnt});
    for (int i = 0; i < int'(cnt); i++) begin
      rd(w);
      chk(w == stat_model(6'(off + 6'(i))), "R6 status", 32'(w), 32'(stat_model(6'(off + 6'(i)))));
    end
  endtask

  task automatic soft_reset(input logic [3:0] t);
    send(8'h6A, {7'd0, 1'b1, 4'h0, t});
    repeat (2) @(posedge clk); #1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
    $finish;
  end

  initial begin : main
    logic [15:0] w;
    int base;
    void'($urandom(32'd12345));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(err == 1'b0 && task_sel == 4'h0, "reset state", {task_sel, 3'd0, err}, 0);
    chk(rd_word == 16'h0abc, "R7 empty read", 32'(rd_word), 32'h0abc);
    rd(w);
    chk(w == 16'h0abc, "R7 default read", 32'(w), 32'h0abc);

    // R1 run, both low opcodes
    base = lg_n;
    send(8'h68, 16'h0fcd);
    send(8'h68, 16'h1400);
    chk(lg_n - base == 2 && lg_kind[base] == 0 && lg_addr[base] == 16'h0fcd,
        "R1 run", 32'(lg_addr[base]), 32'h0fcd);
    chk(lg_addr[base+1] == 16'h1400, "R1 run hi", 32'(lg_addr[base+1]), 32'h1400);

    reg_write(8'haa, 20'h00001);
    reg_read(8'h3c);
    mem_write(1'b0, 3, 11'd100, "R4 bank0");
    mem_write(1'b1, 2, 11'd7, "R4 bank1");
    mem_read(1'b1, 5, 11'd500, "R5 bank1");
    mem_read(1'b0, 1, 11'd0, "R5 bank0");
    stat_read(6'd2, 6'd3);
    stat_read(6'd62, 6'd4);
    chk(err == 1'b0, "R8 no error yet", 32'(err), 0);

    // R11 zero count
    base = lg_n;
    send(8'h68, 16'hA000); send(8'h68, 16'h0000); send(8'h68, 16'h0010);
    send(8'h68, 16'h0123);
    chk(lg_n - base == 1 && lg_kind[base] == 0 && lg_addr[base] == 16'h0123,
        "R11 zero count", 32'(lg_n - base), 1);

    // R12 foreign subaddress
    base = lg_n;
    send(8'h50, 16'h0555);
    send(8'h69, 16'h9123);
    chk(lg_n - base == 0, "R12 ignored", 32'(lg_n - base), 0);
    rd(w);
    chk(w == frame_count, "R12 no response", 32'(w), 32'(frame_count));

    // R8 unknown opcode
    base = lg_n;
    send(8'h68, 16'h5123);
    chk(err == 1'b1, "R8 error set", 32'(err), 1);
    send(8'h68, 16'h0042);
    chk(lg_n - base == 1 && lg_addr[base] == 16'h0042, "R8 recovered", 32'(lg_n - base), 1);

    // R10 software reset and task select
    soft_reset(4'h5);
    chk(err == 1'b0, "R10 err cleared", 32'(err), 0);
    chk(task_sel == 4'h5, "R10 task", 32'(task_sel), 5);
    send(8'h6A, 16'h000c);
    @(posedge clk); #1;
    chk(task_sel == 4'hc, "R10 task no reset", 32'(task_sel), 32'hc);
    send(8'h68, 16'hE000); send(8'h68, 16'd6); send(8'h68, 16'd20);
    repeat (10) @(posedge clk);
    soft_reset(4'h0);
    frame_count = 16'h7e11;
    rd(w);
    chk(w == 16'h7e11, "R10 queue flushed", 32'(w), 32'h7e11);
    reg_read(8'h01);

    // R9 wrap past end of bank
    mem_write(1'b1, 3, 11'd2046, "R9 write wrap");
    chk(err == 1'b1, "R9 err on write wrap", 32'(err), 1);
    soft_reset(4'h0);
    mem_write(1'b0, 1, 11'd2047, "R9 last address");
    chk(err == 1'b0, "R9 no err at end", 32'(err), 0);
    mem_read(1'b0, 2, 11'd2047, "R9 read wrap");
    chk(err == 1'b1, "R9 err on read wrap", 32'(err), 1);
    soft_reset(4'h0);

    // constrained random mix
    for (int k = 0; k < 24; k++) begin
      case ($urandom_range(0, 4))
        0: reg_write(8'($urandom), 20'($urandom));
        1: reg_read(8'($urandom));
        2: mem_write(1'($urandom), int'($urandom_range(1, 4)), 11'($urandom_range(0, 2040)), "R4 random");
        3: mem_read(1'($urandom), int'($urandom_range(1, 6)), 11'($urandom_range(0, 2040)), "R5 random");
        default: stat_read(6'($urandom), 6'($urandom_range(1, 9)));
      endcase
      frame_count = 16'($urandom);
      rd(w);
      chk(w == frame_count, "R7 random default", 32'(w), 32'(frame_count));
    end
    chk(err == 1'b0, "R8 random no error", 32'(err), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule